// File: doc/BRIEF.md
# External Interrupt Trigger Configuration Unit

This unit conditions up to eight external interrupt pins; six by default. Each pin passes through a synchronizer and then through a trigger stage. Software programs that stage for one of five trigger types: high level, low level, rising edge, falling edge, or both edges. Level types follow the synchronized pin. Edge types capture an event in a sticky latch, and software releases that latch by writing one to an acknowledge bit. Each line also has an enable bit that gates its request.

The gated requests go one of two ways, chosen by the `cascade_en` input. In direct mode each request drives its own CPU interrupt input on `cpu_req`. In cascaded mode `cpu_req` is held low, and each request joins the internal interrupt status vector at bit `CASC_BASE + line`. That vector is masked by an internal mask register and appears on `int_pending`. In cascaded mode, writing a line's enable bit also writes the matching internal mask bit, so one register write enables or disables the line on both paths.

Access uses a simple register port with one write channel and one combinational read channel. Addresses 0 and 1 hold the line configuration, packed four 8-bit fields per word. Address 2 is the internal mask. Address 3 is the read-only pending vector.

Top module: `extint_trig`

## Requirements
- R1: After reset every line has enable 0 and the low-level type (level bit 1, polarity bit 0). The internal mask is 0, `cpu_req` is 0, and `int_pending` is 0. With all pins low, address 0 reads 32'h28282828 and address 1 reads 32'h00002828.
- R2: Line i sits in the word at address i/4, in the field at bits [8*(i mod 4)+7 : 8*(i mod 4)]. Within a field, bit 0 is enable, bit 1 is acknowledge, bit 2 is polarity (1 = high/rising), bit 3 is level, bit 4 is both-edge, and bit 5 is the read-only event state. Bits 7:6 read 0, and fields for lines that do not exist read 0.
- R3: With level = 1, the event equals the synchronized pin, inverted when polarity = 0. A pin change reaches `cpu_req` at the second rising clock edge.
- R4: With level = 0 and both-edge = 0, the event latch sets on a rising pin edge when polarity = 1 and on a falling pin edge when polarity = 0. With both-edge = 1 it sets on either edge. The request appears at the third rising clock edge after the pin change.
- R5: A set event latch stays set, whatever the pin does, until it is acknowledged.
- R6: A write with a field's acknowledge bit at 1 clears that line's latch at the same clock edge. The acknowledge bit always reads back as 0.
- R7: If an active edge is detected in the same cycle as an acknowledge, the latch stays set.
- R8: In level types an acknowledge has no effect on the request.
- R9: A line whose enable is 0 never requests, on either path.
- R10: With `cascade_en` = 0, `cpu_req[i]` carries line i's gated request, and the lines add nothing to `int_pending`. Configuration writes leave the internal mask unchanged.
- R11: With `cascade_en` = 1, `cpu_req` is 0, bit `CASC_BASE+i` of the status vector carries line i's gated request, and `int_pending` = (`int_src` OR cascaded bits) AND internal mask.
- R12: With `cascade_en` = 1, a configuration write also copies each written line's enable bit into internal mask bit `CASC_BASE+i`.
- R13: Address 2 reads and writes the whole internal mask, and address 3 reads `int_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | LINES | Asynchronous external interrupt pins |
| cascade_en | input | 1 | 1 routes line requests into the internal status vector |
| int_src | input | DW | Internal interrupt sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0,1 config; 2 internal mask) |
| wr_data | input | DW | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Combinational read data |
| cpu_req | output | LINES | Direct per-line CPU requests |
| int_pending | output | DW | Masked internal status vector |

## Verification
A level-type request is due at the second rising edge after the pin changes, because of the two synchronizer stages. An edge-type request is due at the third rising edge, because the edge-history register and the latch add one more stage. Register writes, acknowledges and mask coupling take effect at the edge that samples the write. The bench changes pins and write strobes only on falling edges and counts whole rising edges before each sample. It checks that a request is still absent one edge early and present on its due edge. The acknowledge collision test places the write in exactly the cycle where the edge is detected.

// File: rtl/extint_trig.sv
module extint_trig #(
  parameter int LINES     = 6,
  parameter int DW        = 32,
  parameter int CASC_BASE = 8,
  parameter int SYNC      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pins,
  input  logic             cascade_en,
  input  logic [DW-1:0]    int_src,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [1:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic [LINES-1:0] cpu_req,
  output logic [DW-1:0]    int_pending
);
  localparam int FW  = 8;
  localparam int FPR = DW / FW;

  logic [LINES-1:0] en_q, pol_q, lvl_q, both_q, lat_q, prev_q;
  logic [LINES-1:0] sync_q [SYNC];
  logic [DW-1:0]    imask_q, imask_d, casc_vec;
  logic [LINES-1:0] pin_s, det, ev, gated, hit, clr, lat_d;
  logic [FW-1:0]    fld [LINES];

  assign pin_s = sync_q[SYNC-1];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam int RI = g / FPR;
    localparam int FO = (g % FPR) * FW;
    logic rise, fall;
    assign fld[g]  = wr_data[FO +: FW];
    assign hit[g]  = wr_en && (wr_addr == 2'(RI));
    assign clr[g]  = hit[g] && fld[g][1];
    assign rise    = pin_s[g] && !prev_q[g];
    assign fall    = !pin_s[g] && prev_q[g];
    assign det[g]  = both_q[g] ? (rise || fall) : (pol_q[g] ? rise : fall);
    assign lat_d[g] = lvl_q[g] ? 1'b0 : (det[g] ? 1'b1 : (clr[g] ? 1'b0 : lat_q[g]));
    assign ev[g]   = lvl_q[g] ? (pol_q[g] ? pin_s[g] : !pin_s[g]) : lat_q[g];
    assign gated[g] = ev[g] && en_q[g];

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |-> !cpu_req[g] && !int_pending[CASC_BASE+g]);
    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_q[g] && !wr_en && !lvl_q[g]) |=> lat_q[g]);
    // R12
    casc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && cascade_en) |=> (imask_q[CASC_BASE+g] == en_q[g]));
    // R6
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 2'(RI)) |-> !rd_data[FO+1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pins;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= pin_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; pol_q <= '0; lvl_q <= '1; both_q <= '0; lat_q <= '0;
      imask_q <= '0;
    end else begin
      lat_q   <= lat_d;
      imask_q <= imask_d;
      for (int i = 0; i < LINES; i++) begin
        if (hit[i]) begin
          en_q[i]   <= fld[i][0];
          pol_q[i]  <= fld[i][2];
          lvl_q[i]  <= fld[i][3];
          both_q[i] <= fld[i][4];
        end
      end
    end
  end

  always_comb begin
    imask_d = imask_q;
    if (wr_en && wr_addr == 2'd2) imask_d = wr_data;
    else if (cascade_en)
      for (int i = 0; i < LINES; i++)
        if (hit[i]) imask_d[CASC_BASE+i] = fld[i][0];
  end

  always_comb begin
    casc_vec = '0;
    for (int i = 0; i < LINES; i++) casc_vec[CASC_BASE+i] = cascade_en && gated[i];
  end

  assign cpu_req     = cascade_en ? '0 : gated;
  assign int_pending = (int_src | casc_vec) & imask_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      2'd2: rd_data = imask_q;
      2'd3: rd_data = int_pending;
      default:
        for (int i = 0; i < LINES; i++)
          if (int'(rd_addr) == i / FPR)
            rd_data[(i % FPR) * FW +: FW] =
              {2'b00, ev[i], both_q[i], lvl_q[i], pol_q[i], 1'b0, en_q[i]};
    endcase
  end

  // R11
  casc_cpu_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cascade_en |-> (cpu_req == '0));
  // R10
  direct_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade_en && !(wr_en && wr_addr == 2'd2)) |=> $stable(imask_q));
endmodule

// File: tb/tb_extint_trig.sv
module tb_extint_trig;
  localparam int LINES = 6;
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LINES-1:0] pins = '0;
  logic             cascade_en = 1'b0;
  logic [DW-1:0]    int_src = '0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [DW-1:0]    wr_data = '0;
  logic [1:0]       rd_addr = '0;
  logic [DW-1:0]    rd_data;
  logic [LINES-1:0] cpu_req;
  logic [DW-1:0]    int_pending;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  extint_trig #(.LINES(LINES), .DW(DW), .CASC_BASE(8), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .cascade_en(cascade_en),
    .int_src(int_src), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cpu_req(cpu_req),
    .int_pending(int_pending));

  // {field, pin_before, pin_after, expected cpu_req[0]}
  localparam logic [10:0] VEC [11] = '{
    {8'h0D, 3'b011}, {8'h0D, 3'b100},   // R3 level high
    {8'h09, 3'b101}, {8'h09, 3'b010},   // R3 level low
    {8'h05, 3'b011}, {8'h05, 3'b100},   // R4 rising
    {8'h01, 3'b101}, {8'h01, 3'b010},   // R4 falling
    {8'h11, 3'b011}, {8'h11, 3'b101},   // R4 both edges
    {8'h04, 3'b010}                     // R9 enable off
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 cpu_req", 32'(cpu_req), 32'h0);
    chk("R1 int_pending", int_pending, 32'h0);
    rd(2'd0, v); chk("R1 cfg0", v, 32'h28282828);
    rd(2'd1, v); chk("R1 cfg1", v, 32'h00002828);
    rd(2'd2, v); chk("R1 imask", v, 32'h0);

    // R3 R4 R9 vector walk on line 0
    for (int k = 0; k < 11; k++) begin
      logic [7:0] f;
      f = VEC[k][10:3];
      pins[0] = VEC[k][2];
      wr(2'd0, 32'(f | 8'h02));
      tick(4);
      wr(2'd0, 32'(f | 8'h02));
      pins[0] = VEC[k][1];
      tick(4);
      chk($sformatf("R3/R4/R9 vector %0d", k), 32'(cpu_req[0]), 32'(VEC[k][0]));
    end

    // R3 level latency: two edges
    pins[0] = 1'b0;
    wr(2'd0, 32'h0D);
    tick(3);
    pins[0] = 1'b1;
    tick(1); chk("R3 early", 32'(cpu_req[0]), 32'h0);
    tick(1); chk("R3 due", 32'(cpu_req[0]), 32'h1);

    // R4 edge latency: three edges
    pins[0] = 1'b0;
    wr(2'd0, 32'h07);
    tick(3);
    wr(2'd0, 32'h07);
    pins[0] = 1'b1;
    tick(2); chk("R4 early", 32'(cpu_req[0]), 32'h0);
    tick(1); chk("R4 due", 32'(cpu_req[0]), 32'h1);

    // R5 hold after pin returns
    pins[0] = 1'b0;
    tick(4); chk("R5 hold", 32'(cpu_req[0]), 32'h1);
    rd(2'd0, v); chk("R2 R5 field readback", v, 32'h00000025);

    // R6 acknowledge
    wr(2'd0, 32'h07);
    chk("R6 cleared", 32'(cpu_req[0]), 32'h0);
    rd(2'd0, v); chk("R6 ack reads zero", v, 32'h00000005);

    // R7 edge beats acknowledge in the same cycle
    wr(2'd0, 32'h13);
    pins[0] = 1'b1;
    tick(3); chk("R7 set by rise", 32'(cpu_req[0]), 32'h1);
    pins[0] = 1'b0;
    tick(2);
    wr(2'd0, 32'h13);
    chk("R7 edge wins", 32'(cpu_req[0]), 32'h1);
    wr(2'd0, 32'h13);
    chk("R6 plain ack", 32'(cpu_req[0]), 32'h0);

    // R8 acknowledge ignored in level type
    wr(2'd0, 32'h0D);
    pins[0] = 1'b1;
    tick(3);
    wr(2'd0, 32'h0F);
    chk("R8 level ack", 32'(cpu_req[0]), 32'h1);

    // R2 line 5 in second word, field 1
    wr(2'd1, 32'h00000D00);
    pins[5] = 1'b1;
    tick(3);
    chk("R2 line5 req", 32'(cpu_req), 32'h21);
    rd(2'd1, v); chk("R2 cfg1", v, 32'h00002D00);

    // R10 direct mode
    wr(2'd2, 32'h00003F00);
    chk("R10 no pending", int_pending, 32'h0);
    wr(2'd0, 32'h0C);
    rd(2'd2, v); chk("R10 imask untouched", v, 32'h00003F00);
    wr(2'd0, 32'h0D);

    // R11 cascaded mode
    cascade_en = 1'b1;
    #1;
    chk("R11 cpu quiet", 32'(cpu_req), 32'h0);
    chk("R11 pending", int_pending, 32'h00002100);
    int_src = 32'h1;
    #1;
    chk("R11 src masked", int_pending, 32'h00002100);
    wr(2'd2, 32'h00003F01);
    rd(2'd3, v); chk("R13 pending readback", v, 32'h00002101);

    // R12 mask coupling
    wr(2'd0, 32'h0C);
    rd(2'd2, v); chk("R12 imask follows", v, 32'h00003001);
    chk("R12 pending", int_pending, 32'h00002001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule